// File: doc/BRIEF.md
# Duty-Modulated Clock-Embedding Line Encoder

This block turns a stream of single data bits into one serial line that carries both the data and its own timing. It runs on a fast clock whose rate is a whole multiple of the bit rate: twenty fast cycles, called slots, make up one bit period. Every period begins with the line going high, so a receiver can recover the bit clock from the rising edges alone. The bit value is carried only by the slot in which the line drops back low. A one drops early and gives a short high pulse. A zero drops late and gives a long high pulse.

A free-running slot counter paces the block. In the last slot of each period the encoder raises a one-cycle ready strobe. If the producer holds valid high in that slot, the bit on the data input is taken for the next period. If it does not, the encoder sends a filler one, so the rising edges never stop. The data input is looked at only in that capture slot. After reset the line stays low for one full lead-in period while the first bit is fetched. The first rising edge comes at the start of the following period.

Top module: `dm_edge_encoder`

## Requirements
- R1: A bit period lasts SLOTS (default 20) fast cycles, counted from slot 0 to slot SLOTS-1. In every period after the lead-in, the line is high in slot 0 whatever the bit value is.
- R2: A bit value of 1 keeps the line high in slots 0 to FALL_ONE-1 (default 0..7, eight cycles) and low in every later slot of the period.
- R3: A bit value of 0 keeps the line high in slots 0 to FALL_ZERO-1 (default 0..11, twelve cycles) and low in every later slot of the period.
- R4: The ready output is high for exactly one fast cycle per period, in slot SLOTS-1, and low in every other slot.
- R5: The data input is captured only at the clock edge that ends a slot in which both ready and valid are high. A change on the data input at any other time does not alter the bit being sent.
- R6: If valid is low in the capture slot, the next period carries the filler value 1, which gives the short high pulse.
- R7: While reset is high, the line and ready are low and the slot counter is held at 0. After release, the first period is a silent lead-in. The first rising edge comes in the slot 0 that follows the first ready strobe.
- R8: Each period after the lead-in has exactly one rising edge and one falling edge on the line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock, SLOTS times the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Producer offers a bit |
| in_data | input | 1 | Bit value offered |
| in_ready | output | 1 | One-cycle strobe in the capture slot |
| tx_line | output | 1 | Encoded serial line, registered |

## Verification
The hardest case to reach from the ports is a mismatch between what the producer shows during the period and what it shows in the one capture slot. The stimulus toggles the data input in every slot except the capture slot, and shows the opposite value there. It also withdraws valid exactly in the capture slot, so that the filler path is taken. A reset is also applied in the middle of a long high pulse, which checks that the lead-in starts again. Pulse widths and edge counts are totalled for each period and compared with the bit that the bench model expects.

// File: rtl/dme_pkg.sv
package dme_pkg;

    localparam int DEF_SLOTS     = 20;
    localparam int DEF_FALL_ONE  = 8;
    localparam int DEF_FALL_ZERO = 12;

    // symbol carried through one bit period
    typedef struct packed {
        logic armed;   // lead-in finished, line may pulse
        logic val;     // bit value being sent
    } sym_t;

    // number of high slots for a given bit value
    function automatic int high_slots(input logic val, input int f_one, input int f_zero);
        return val ? f_one : f_zero;
    endfunction

endpackage

// File: rtl/dme_slot_counter.sv
module dme_slot_counter #(
    parameter int SLOTS = dme_pkg::DEF_SLOTS,
    localparam int PW   = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [PW-1:0] slot_q,
    output logic [PW-1:0] slot_nxt,
    output logic          last_slot
);
    localparam logic [PW-1:0] LAST = PW'(SLOTS - 1);

    assign last_slot = (slot_q == LAST);

    always_comb begin
        if (rst)
            slot_nxt = '0;
        else if (last_slot)
            slot_nxt = '0;
        else
            slot_nxt = slot_q + PW'(1);
    end

    always_ff @(posedge clk) begin
        slot_q <= slot_nxt;
    end
endmodule

// File: rtl/dme_bit_capture.sv
module dme_bit_capture #(
    parameter logic FILL_BIT = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           take,
    input  logic           in_valid,
    input  logic           in_data,
    output dme_pkg::sym_t  sym_q,
    output dme_pkg::sym_t  sym_nxt
);
    always_comb begin
        sym_nxt = sym_q;
        if (rst) begin
            sym_nxt.armed = 1'b0;
            sym_nxt.val   = FILL_BIT;
        end else if (take) begin
            sym_nxt.armed = 1'b1;
            sym_nxt.val   = in_valid ? in_data : FILL_BIT;
        end
    end

    always_ff @(posedge clk) begin
        sym_q <= sym_nxt;
    end
endmodule

// File: rtl/dme_wave_shaper.sv
module dme_wave_shaper #(
    parameter int SLOTS     = dme_pkg::DEF_SLOTS,
    parameter int FALL_ONE  = dme_pkg::DEF_FALL_ONE,
    parameter int FALL_ZERO = dme_pkg::DEF_FALL_ZERO,
    localparam int PW       = $clog2(SLOTS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [PW-1:0]  slot_nxt,
    input  dme_pkg::sym_t  sym_nxt,
    output logic           line_q
);
    logic line_d;

    always_comb begin
        line_d = 1'b0;
        if (!rst && sym_nxt.armed)
            line_d = (int'(slot_nxt) < dme_pkg::high_slots(sym_nxt.val, FALL_ONE, FALL_ZERO));
    end

    always_ff @(posedge clk) begin
        line_q <= line_d;
    end
endmodule

// File: rtl/dm_edge_encoder.sv
module dm_edge_encoder #(
    parameter int   SLOTS     = dme_pkg::DEF_SLOTS,
    parameter int   FALL_ONE  = dme_pkg::DEF_FALL_ONE,
    parameter int   FALL_ZERO = dme_pkg::DEF_FALL_ZERO,
    parameter logic FILL_BIT  = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_data,
    output logic in_ready,
    output logic tx_line
);
    localparam int PW = $clog2(SLOTS);

    logic [PW-1:0] slot_q;
    logic [PW-1:0] slot_nxt;
    logic          last_slot;
    dme_pkg::sym_t sym_q;
    dme_pkg::sym_t sym_nxt;

    dme_slot_counter #(.SLOTS(SLOTS)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .slot_q    (slot_q),
        .slot_nxt  (slot_nxt),
        .last_slot (last_slot)
    );

    dme_bit_capture #(.FILL_BIT(FILL_BIT)) u_cap (
        .clk      (clk),
        .rst      (rst),
        .take     (last_slot),
        .in_valid (in_valid),
        .in_data  (in_data),
        .sym_q    (sym_q),
        .sym_nxt  (sym_nxt)
    );

    dme_wave_shaper #(
        .SLOTS     (SLOTS),
        .FALL_ONE  (FALL_ONE),
        .FALL_ZERO (FALL_ZERO)
    ) u_shape (
        .clk      (clk),
        .rst      (rst),
        .slot_nxt (slot_nxt),
        .sym_nxt  (sym_nxt),
        .line_q   (tx_line)
    );

    assign in_ready = last_slot;
endmodule

// File: rtl/dm_edge_encoder_chk.sv
module dm_edge_encoder_chk #(
    parameter int   SLOTS     = 20,
    parameter int   FALL_ONE  = 8,
    parameter int   FALL_ZERO = 12,
    parameter logic FILL_BIT  = 1'b1,
    localparam int  PW        = $clog2(SLOTS)
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_ready,
    input logic          tx_line,
    input logic [PW-1:0] slot_q,
    input dme_pkg::sym_t sym_q
);
    // a strobe never lasts two cycles
    p_ready_single_r4: assert property (@(posedge clk) disable iff (rst)
        in_ready |=> !in_ready);

    // every period opens with the line high
    p_opens_high_r1: assert property (@(posedge clk) disable iff (rst)
        in_ready |=> tx_line);

    // a rising edge only follows a capture slot
    p_rise_after_ready_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_line) |-> $past(in_ready));

    // falling edges land only on the two coding slots (R2, R3)
    p_fall_slot_r2: assert property (@(posedge clk) disable iff (rst)
        ($fell(tx_line) && !$past(rst)) |->
            (int'(slot_q) == FALL_ONE || int'(slot_q) == FALL_ZERO));

    // the sent symbol is frozen outside the capture slot
    p_bit_held_r5: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && !rst) |=> $stable(sym_q));

    // missing data yields the filler value
    p_filler_r6: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> (sym_q.val == FILL_BIT));

    // reset forces line and strobe low
    p_reset_quiet_r7: assert property (@(posedge clk)
        rst |=> (!tx_line && !in_ready));
endmodule

bind dm_edge_encoder dm_edge_encoder_chk #(
    .SLOTS     (SLOTS),
    .FALL_ONE  (FALL_ONE),
    .FALL_ZERO (FALL_ZERO),
    .FILL_BIT  (FILL_BIT)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .tx_line  (tx_line),
    .slot_q   (slot_q),
    .sym_q    (sym_q)
);

// File: tb/dm_edge_encoder_test.sv
module dm_edge_encoder_test;
    localparam int SLOTS = 20;
    localparam int F1    = 8;
    localparam int F0    = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_data  = 1'b0;
    logic in_ready;
    logic tx_line;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // behavioural reference state
    int   m_slot  = 0;
    bit   m_armed = 0;
    bit   m_bit   = 1;
    bit   m_fill  = 0;
    int   hi_cnt  = 0;
    int   rises   = 0;
    bit   prev_tx = 0;
    bit   wd_done = 0;

    dm_edge_encoder uut (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_ready (in_ready),
        .tx_line  (tx_line)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cycles, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic v, input logic d);
        bit exp_rdy;
        bit exp_tx;
        @(negedge clk);
        exp_rdy = (m_slot == SLOTS - 1);
        exp_tx  = m_armed && (m_slot < (m_bit ? F1 : F0));
        check(in_ready == exp_rdy, "R4 ready", int'(in_ready), int'(exp_rdy));
        if (!m_armed)
            check(tx_line == exp_tx, "R7 line", int'(tx_line), int'(exp_tx));
        else if (m_slot == 0)
            check(tx_line == exp_tx, "R1 line", int'(tx_line), int'(exp_tx));
        else
            check(tx_line == exp_tx, m_bit ? "R2 line" : "R3 line", int'(tx_line), int'(exp_tx));
        if (m_armed) begin
            if (m_slot == 0) begin hi_cnt = 0; rises = 0; end
            if (tx_line) hi_cnt++;
            if (tx_line && !prev_tx) rises++;
            if (m_slot == SLOTS - 1) begin
                check(rises == 1, "R8 edges", rises, 1);
                if (m_fill)
                    check(hi_cnt == F1, "R6 filler width", hi_cnt, F1);
                else
                    check(hi_cnt == (m_bit ? F1 : F0), m_bit ? "R2 width" : "R3 width",
                          hi_cnt, m_bit ? F1 : F0);
            end
        end
        prev_tx  = tx_line;
        rst      = r;
        in_valid = v;
        in_data  = d;
        @(posedge clk);
        if (r) begin
            m_slot = 0; m_armed = 0; m_bit = 1; m_fill = 0;
        end else if (m_slot == SLOTS - 1) begin
            m_armed = 1;
            m_fill  = !v;
            m_bit   = v ? d : 1'b1;
            m_slot  = 0;
        end else begin
            m_slot++;
        end
    endtask

    // send one bit; wig toggles data outside the capture slot (R5)
    task automatic put_bit(input bit v, input bit b, input bit wig);
        bit t;
        t = ~b;
        while (m_slot != SLOTS - 1) begin
            step(1'b0, 1'b1, wig ? t : b);
            t = ~t;
        end
        step(1'b0, v, b);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !wd_done) begin
                wd_done = 1;
                errors++;
                checks++;
                $display("FAIL watchdog R1: actual=%0d expected<=%0d", cycles, 100000);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        // R7: reset state
        for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0);
        // R7: lead-in period after release, first bit fetched
        put_bit(1'b1, 1'b1, 1'b0);
        // R2: run of ones
        for (int i = 0; i < 3; i++) put_bit(1'b1, 1'b1, 1'b0);
        // R3: run of zeros
        for (int i = 0; i < 3; i++) put_bit(1'b1, 1'b0, 1'b0);
        // R2/R3 alternating
        for (int i = 0; i < 6; i++) put_bit(1'b1, i[0], 1'b0);
        // R5: data wiggles outside the capture slot
        for (int i = 0; i < 6; i++) put_bit(1'b1, i[1], 1'b1);
        // R6: idle, filler pulses
        for (int i = 0; i < 3; i++) put_bit(1'b0, 1'b0, 1'b0);
        put_bit(1'b1, 1'b0, 1'b0);
        // R7: reset in the middle of a long pulse
        for (int i = 0; i < 4; i++) step(1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b1, 1'b0);
        put_bit(1'b1, 1'b0, 1'b0);
        for (int i = 0; i < 4; i++) put_bit(1'b1, ~i[0], 1'b1);
        put_bit(1'b0, 1'b1, 1'b0);
        for (int i = 0; i < SLOTS; i++) step(1'b0, 1'b0, 1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule